// File: doc/BRIEF.md
# In-Place Radix-2 FFT Address Sequencer

This block drives the address ports of a dual-port sample memory and a twiddle-factor ROM for an in-place radix-2 decimation-in-time transform of N = 2^M points. A controller chooses what the sequencer does through a two-bit mode input.

In fill mode it writes samples to consecutive locations. In butterfly mode it walks every butterfly of every stage. For each butterfly it gives both operand addresses in the same cycle, and the results go back to those same two locations. It also gives the matching twiddle index and reports the current stage and butterfly number. In drain mode it reads the memory at bit-reversed addresses.

Each sequence issues one address per cycle. It starts in the very cycle its mode appears on the input. A one-cycle done pulse follows the last address of the sequence. The sequencer then stays quiet until the mode changes, and any change of mode restarts the counters at zero.

Top module: `fft_agu`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `addr_valid_o`, `wr_en_o` and `done_o` are 0.
- R2: With mode 2'b00 (idle), `addr_valid_o` and `wr_en_o` stay 0 and no done pulse is raised.
- R3: Mode 2'b01 (fill) issues addresses 0, 1, …, N−1 on `addr_a_o`, one per cycle, starting in the cycle the mode is first applied, with `addr_valid_o` and `wr_en_o` both 1.
- R4: Mode 2'b10 (butterfly) visits stage s = 0 … M−1 in order. Within each stage it visits butterfly k = 0 … N/2−1 in order, one per cycle. `stage_o` reports s, `bfly_o` reports k, and `wr_en_o` is 0.
- R5: For butterfly k of stage s, `addr_a_o` = (k div 2^s)·2^(s+1) + (k mod 2^s) and `addr_b_o` = `addr_a_o` + 2^s.
- R6: For butterfly k of stage s, `tw_addr_o` = (k mod 2^s)·N/2^(s+1), so it is 0 throughout stage 0.
- R7: Mode 2'b11 (drain) issues on `addr_a_o`, for i = 0 … N−1, the M-bit reversal of i (bit j of i goes to bit M−1−j), with `wr_en_o` 0.
- R8: `done_o` is high for exactly one cycle: the cycle after the last address of a fill, butterfly or drain sequence. While the mode is then held, `addr_valid_o` stays 0.
- R9: A change of mode restarts the counters, so the first address of the new sequence appears in the same cycle as the new mode, even if the previous sequence was cut off part-way.
- R10: A complete butterfly sequence issues exactly M·N/2 addresses; a fill or drain sequence issues exactly N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | 00 idle, 01 fill, 10 butterfly, 11 drain |
| addr_valid_o | output | 1 | An address is issued this cycle |
| wr_en_o | output | 1 | The issued address is a fill write |
| addr_a_o | output | M | Fill/drain address, or upper-less (first) operand address |
| addr_b_o | output | M | Second operand address (butterfly mode only, else 0) |
| tw_addr_o | output | M−1 | Twiddle ROM index (butterfly mode only, else 0) |
| stage_o | output | max(1,clog2(M)) | Current stage (butterfly mode only, else 0) |
| bfly_o | output | M−1 | Butterfly number in the stage (butterfly mode only, else 0) |
| done_o | output | 1 | One-cycle pulse after the last address of a sequence |

## Verification
Every counter value is combined into the outputs in the same cycle, so a wrong stage or butterfly count shows at once. It appears as a wrong operand pair, a wrong twiddle index, or a `stage_o`/`bfly_o` value that breaks the expected order. A wrong wrap or end test shows up differently: the done pulse comes one or more cycles early or late, or is missing, and addresses keep coming after the sequence should have ended. A stale counter after a mode change shows on the first cycle of the new mode as a non-zero first address.

// File: rtl/fftag_pkg.sv
package fftag_pkg;

    typedef enum logic [1:0] {
        AG_IDLE  = 2'b00,
        AG_FILL  = 2'b01,
        AG_BFLY  = 2'b10,
        AG_DRAIN = 2'b11
    } ag_mode_e;

    // Width of a stage index for M stages (at least one bit).
    function automatic int stage_bits(input int m);
        return (m > 1) ? $clog2(m) : 1;
    endfunction

endpackage

// File: rtl/agu_step_ctr.sv
module agu_step_ctr
    import fftag_pkg::*;
#(
    parameter int M = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fresh_i,
    input  logic                     active_i,
    input  logic                     bfly_i,
    output logic [M-1:0]             cnt_o,
    output logic [stage_bits(M)-1:0] stg_o,
    output logic                     fin_o,
    output logic                     last_o
);
    localparam int SW = stage_bits(M);
    localparam logic [M-1:0]  CNT_MAX  = {M{1'b1}};
    localparam logic [M-1:0]  HALF_MAX = {1'b0, {(M-1){1'b1}}};
    localparam logic [SW-1:0] STG_MAX  = SW'(M - 1);

    logic [M-1:0]  cnt_q, cnt_e;
    logic [SW-1:0] stg_q, stg_e;
    logic          fin_q, fin_e;
    logic          k_wrap;

    always_comb begin
        cnt_e  = fresh_i ? '0 : cnt_q;
        stg_e  = fresh_i ? '0 : stg_q;
        fin_e  = fresh_i ? 1'b0 : fin_q;
        k_wrap = (cnt_e == HALF_MAX);
        last_o = bfly_i ? (k_wrap && (stg_e == STG_MAX)) : (cnt_e == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            stg_q <= '0;
            fin_q <= 1'b0;
        end else if (active_i) begin
            if (last_o) begin
                cnt_q <= '0;
                stg_q <= '0;
                fin_q <= 1'b1;
            end else if (bfly_i && k_wrap) begin
                cnt_q <= '0;
                stg_q <= stg_e + 1'b1;
                fin_q <= 1'b0;
            end else begin
                cnt_q <= cnt_e + 1'b1;
                stg_q <= stg_e;
                fin_q <= 1'b0;
            end
        end else begin
            cnt_q <= cnt_e;
            stg_q <= stg_e;
            fin_q <= fin_e;
        end
    end

    assign cnt_o = cnt_e;
    assign stg_o = stg_e;
    assign fin_o = fin_e;
endmodule

// File: rtl/agu_pair_map.sv
module agu_pair_map
    import fftag_pkg::*;
#(
    parameter int M = 8
) (
    input  logic [M-2:0]             k_i,
    input  logic [stage_bits(M)-1:0] s_i,
    output logic [M-1:0]             top_o,
    output logic [M-1:0]             bot_o,
    output logic [M-2:0]             tw_o
);
    localparam int SW = stage_bits(M);

    logic [M-1:0] span;
    logic [M-1:0] mask_full;
    logic [M-2:0] low, high;
    logic [SW-1:0] tw_shift;

    always_comb begin
        span      = {{(M-1){1'b0}}, 1'b1} << s_i;
        mask_full = span - {{(M-1){1'b0}}, 1'b1};
        low       = k_i & mask_full[M-2:0];
        high      = k_i & ~mask_full[M-2:0];
        top_o     = {high, 1'b0} | {1'b0, low};
        bot_o     = top_o | span;
        tw_shift  = SW'(M - 1) - s_i;
        tw_o      = low << tw_shift;
    end
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
    parameter int M = 8
) (
    input  logic [M-1:0] idx_i,
    output logic [M-1:0] rev_o
);
    for (genvar j = 0; j < M; j++) begin : g_swap
        assign rev_o[M-1-j] = idx_i[j];
    end
endmodule

// File: rtl/fft_agu.sv
module fft_agu
    import fftag_pkg::*;
#(
    parameter int N = 256
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [1:0]                          mode_i,
    output logic                                addr_valid_o,
    output logic                                wr_en_o,
    output logic [$clog2(N)-1:0]                addr_a_o,
    output logic [$clog2(N)-1:0]                addr_b_o,
    output logic [$clog2(N)-2:0]                tw_addr_o,
    output logic [stage_bits($clog2(N))-1:0]    stage_o,
    output logic [$clog2(N)-2:0]                bfly_o,
    output logic                                done_o
);
    localparam int M  = $clog2(N);
    localparam int SW = stage_bits(M);

    ag_mode_e      mode, mode_q;
    logic          fresh, active, is_bfly;
    logic [M-1:0]  cnt;
    logic [SW-1:0] stg;
    logic          fin, last;
    logic [M-1:0]  top, bot, rev;
    logic [M-2:0]  tw;
    logic          done_q;

    assign mode    = ag_mode_e'(mode_i);
    assign fresh   = (mode != mode_q);
    assign is_bfly = (mode == AG_BFLY);
    assign active  = (mode != AG_IDLE) && !fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= AG_IDLE;
            done_q <= 1'b0;
        end else begin
            mode_q <= mode;
            done_q <= active && last;
        end
    end

    agu_step_ctr #(.M(M)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .fresh_i  (fresh),
        .active_i (active),
        .bfly_i   (is_bfly),
        .cnt_o    (cnt),
        .stg_o    (stg),
        .fin_o    (fin),
        .last_o   (last)
    );

    agu_pair_map #(.M(M)) u_map (
        .k_i   (cnt[M-2:0]),
        .s_i   (stg),
        .top_o (top),
        .bot_o (bot),
        .tw_o  (tw)
    );

    agu_bitrev #(.M(M)) u_rev (
        .idx_i (cnt),
        .rev_o (rev)
    );

    always_comb begin
        addr_valid_o = active;
        wr_en_o      = active && (mode == AG_FILL);
        addr_a_o     = '0;
        addr_b_o     = '0;
        tw_addr_o    = '0;
        stage_o      = '0;
        bfly_o       = '0;
        if (active) begin
            unique case (mode)
                AG_FILL:  addr_a_o = cnt;
                AG_DRAIN: addr_a_o = rev;
                AG_BFLY: begin
                    addr_a_o  = top;
                    addr_b_o  = bot;
                    tw_addr_o = tw;
                    stage_o   = stg;
                    bfly_o    = cnt[M-2:0];
                end
                default: ;
            endcase
        end
        done_o = done_q;
    end
endmodule

// File: rtl/fft_agu_chk.sv
module fft_agu_chk
    import fftag_pkg::*;
#(
    parameter int N = 256
) (
    input logic                                clk,
    input logic                                rst,
    input logic [1:0]                          mode_i,
    input logic                                addr_valid_o,
    input logic                                wr_en_o,
    input logic [$clog2(N)-1:0]                addr_a_o,
    input logic [$clog2(N)-1:0]                addr_b_o,
    input logic [$clog2(N)-2:0]                tw_addr_o,
    input logic [stage_bits($clog2(N))-1:0]    stage_o,
    input logic [$clog2(N)-2:0]                bfly_o,
    input logic                                done_o
);
    localparam int M = $clog2(N);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00) |-> (!addr_valid_o && !wr_en_o));

    // R3
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid_o && mode_i == 2'b01 && $past(addr_valid_o) && $past(mode_i) == 2'b01)
        |-> (addr_a_o == $past(addr_a_o) + 1'b1));

    // R4
    stage_order_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid_o && mode_i == 2'b10 && $past(addr_valid_o) && $past(mode_i) == 2'b10)
        |-> ((stage_o == $past(stage_o)) || (stage_o == $past(stage_o) + 1'b1)));

    // R5
    pair_split_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid_o && mode_i == 2'b10)
        |-> (((addr_a_o ^ addr_b_o) >> stage_o) == 1 && !addr_a_o[stage_o]));

    // R6
    tw_stage0_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid_o && mode_i == 2'b10 && stage_o == 0) |-> (tw_addr_o == 0));

    // R7
    drain_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11) |-> !wr_en_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && mode_i == $past(mode_i)) |-> !addr_valid_o);

    // R4
    stage_range_chk: assert property (@(posedge clk) disable iff (rst)
        addr_valid_o |-> (int'(stage_o) < M));
endmodule

bind fft_agu fft_agu_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode_i),
    .addr_valid_o (addr_valid_o),
    .wr_en_o      (wr_en_o),
    .addr_a_o     (addr_a_o),
    .addr_b_o     (addr_b_o),
    .tw_addr_o    (tw_addr_o),
    .stage_o      (stage_o),
    .bfly_o       (bfly_o),
    .done_o       (done_o)
);

// File: tb/fft_agu_test.sv
`timescale 1ns/1ps
module fft_agu_test;
    localparam int N  = 8;
    localparam int M  = 3;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode_i = 2'b00;
    logic          addr_valid_o, wr_en_o, done_o;
    logic [M-1:0]  addr_a_o, addr_b_o;
    logic [M-2:0]  tw_addr_o, bfly_o;
    logic [SW-1:0] stage_o;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    fft_agu #(.N(N)) uut (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .addr_valid_o(addr_valid_o), .wr_en_o(wr_en_o),
        .addr_a_o(addr_a_o), .addr_b_o(addr_b_o), .tw_addr_o(tw_addr_o),
        .stage_o(stage_o), .bfly_o(bfly_o), .done_o(done_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int brev(input int i);
        int r = 0;
        for (int j = 0; j < M; j++) if (i[j]) r |= (1 << (M - 1 - j));
        return r;
    endfunction

    // Each address step: outputs checked 1 ns after the negedge that set the mode.
    task automatic run_fill();
        @(negedge clk); mode_i = 2'b01;
        for (int i = 0; i < N; i++) begin
            #1;
            chk("R3 valid", addr_valid_o, 1);
            chk("R3 wr_en", wr_en_o, 1);
            chk("R3 addr", addr_a_o, i);
            chk("R8 done early", done_o, 0);
            @(negedge clk);
        end
        #1;
        chk("R8 done pulse", done_o, 1);
        chk("R10 fill count", addr_valid_o, 0);
        @(negedge clk); #1;
        chk("R8 done single", done_o, 0);
        chk("R8 quiet held", addr_valid_o, 0);
        @(negedge clk); mode_i = 2'b00;
    endtask

    task automatic run_bfly();
        @(negedge clk); mode_i = 2'b10;
        for (int s = 0; s < M; s++) begin
            for (int k = 0; k < N/2; k++) begin
                int top, tw;
                top = (k >> s) * (2 << s) + (k % (1 << s));
                tw  = (k % (1 << s)) * (N >> (s + 1));
                #1;
                chk("R4 valid", addr_valid_o, 1);
                chk("R4 wr_en", wr_en_o, 0);
                chk("R4 stage", stage_o, s);
                chk("R4 bfly", bfly_o, k);
                chk("R5 top", addr_a_o, top);
                chk("R5 bot", addr_b_o, top + (1 << s));
                chk("R6 twiddle", tw_addr_o, tw);
                chk("R8 done early", done_o, 0);
                @(negedge clk);
            end
        end
        #1;
        chk("R8 done pulse", done_o, 1);
        chk("R10 bfly count", addr_valid_o, 0);
        @(negedge clk); #1;
        chk("R8 done single", done_o, 0);
        chk("R8 quiet held", addr_valid_o, 0);
        @(negedge clk); mode_i = 2'b00;
    endtask

    task automatic run_drain();
        @(negedge clk); mode_i = 2'b11;
        for (int i = 0; i < N; i++) begin
            #1;
            chk("R7 valid", addr_valid_o, 1);
            chk("R7 wr_en", wr_en_o, 0);
            chk("R7 addr", addr_a_o, brev(i));
            @(negedge clk);
        end
        #1;
        chk("R8 done pulse", done_o, 1);
        chk("R10 drain count", addr_valid_o, 0);
        @(negedge clk); mode_i = 2'b00;
    endtask

    task automatic run_idle();
        @(negedge clk); mode_i = 2'b00;
        for (int i = 0; i < 4; i++) begin
            #1;
            chk("R2 valid", addr_valid_o, 0);
            chk("R2 wr_en", wr_en_o, 0);
            chk("R2 done", done_o, 0);
            @(negedge clk);
        end
    endtask

    task automatic run_restart();
        @(negedge clk); mode_i = 2'b10;
        for (int i = 0; i < 3; i++) begin
            #1; chk("R9 bfly pre", bfly_o, i);
            @(negedge clk);
        end
        mode_i = 2'b01;
        for (int i = 0; i < N; i++) begin
            #1;
            chk("R9 restart addr", addr_a_o, i);
            chk("R9 restart valid", addr_valid_o, 1);
            @(negedge clk);
        end
        #1; chk("R9 done after restart", done_o, 1);
        // cut a fill short, then switch to drain: must start at reversal of 0
        @(negedge clk); mode_i = 2'b00;
        @(negedge clk); mode_i = 2'b01;
        #1; chk("R9 refill addr", addr_a_o, 0);
        @(negedge clk); #1; chk("R9 refill step", addr_a_o, 1);
        @(negedge clk); mode_i = 2'b11;
        #1; chk("R9 drain start", addr_a_o, brev(0));
        @(negedge clk); #1; chk("R9 drain second", addr_a_o, brev(1));
        @(negedge clk); mode_i = 2'b00;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 valid in reset", addr_valid_o, 0);
        chk("R1 done in reset", done_o, 0);
        chk("R1 wr_en in reset", wr_en_o, 0);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 valid after reset", addr_valid_o, 0);
        chk("R1 done after reset", done_o, 0);
        run_idle();
        run_fill();
        run_bfly();
        run_drain();
        run_restart();
        run_idle();
        run_fill();
        ended = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!ended) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule